// File: doc/BRIEF.md
# Serial Channel Diagnostic Loop Router

This block sits between the serial pins of an asynchronous serial channel and the channel's transmit and receive shift registers. A two-bit diagnostic mode per channel decides what drives the outgoing line, what the receive shifter samples, and whether the CPU may write a character to the transmitter or read one from the receiver. Shifters, baud timing and FIFOs live elsewhere. This block only routes bits and gates the two CPU links.

Four modes exist. In normal operation the two directions are independent. In automatic echo the incoming line is sent straight back out bit by bit, and the CPU loses its transmit link. In local loopback the transmit shifter feeds the receive shifter internally, and the outgoing line rests at mark. In remote loopback the line is echoed and the CPU loses both links. The outgoing line always passes through one register, so it is glitch-free and lags its source by exactly one clock. Several channels are built side by side from one parameter, and each channel runs on its own mode and enable.

Top module: `uart_loopback_router`

## Requirements
- R1: Mode code 2'b00 (normal) with transmitter enabled: tx_pin equals tx_shift_out as sampled at the previous rising clock edge, rx_shift_in equals rx_pin in the same cycle, and both grants equal their requests in the same cycle.
- R2: Mode code 2'b00 with the transmitter disabled: tx_pin is 1 (mark) after the next edge, whatever tx_shift_out does.
- R3: Mode code 2'b01 (automatic echo): tx_pin equals rx_pin as sampled at the previous edge, whatever tx_en and tx_shift_out are, and rx_shift_in equals rx_pin.
- R4: Mode code 2'b01: tx_wr_gnt is 0 for any request, and rx_rd_gnt equals rx_rd_req.
- R5: Mode code 2'b10 (local loopback): tx_pin is 1 after the next edge, and rx_shift_in equals tx_shift_out in the same cycle with rx_pin ignored.
- R6: Mode code 2'b10: both grants equal their requests.
- R7: Mode code 2'b11 (remote loopback): tx_pin equals rx_pin as sampled at the previous edge, rx_shift_in equals rx_pin, and both grants are 0.
- R8: While rst_n is low at a rising edge, tx_pin is 1 after that edge in every mode.
- R9: A change of mode changes tx_pin only at the next rising edge; until then tx_pin keeps the value set by the old mode.
- R10: Each channel follows its own mode, enable and pins, whatever the other channels do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2*NUM_CH | Per-channel mode code, channel i in bits [2i+1:2i] |
| tx_en | input | NUM_CH | Per-channel transmitter enable |
| rx_pin | input | NUM_CH | Incoming serial line |
| tx_pin | output | NUM_CH | Outgoing serial line, registered |
| tx_shift_out | input | NUM_CH | Bit from the transmit shifter |
| rx_shift_in | output | NUM_CH | Bit fed to the receive shifter |
| tx_wr_req | input | NUM_CH | CPU request to write the transmitter |
| tx_wr_gnt | output | NUM_CH | Write accepted |
| rx_rd_req | input | NUM_CH | CPU request to read the receiver |
| rx_rd_gnt | output | NUM_CH | Read accepted |

## Verification
A mode switch and a bit on the echo path can fall on the same edge. The single output register then has to take the source of the new mode and not the old one. The bench switches from remote loopback to local loopback with rx_pin low. It checks that tx_pin is still low just before the edge and at mark just after it. Reset and echo also meet: reset is held in echo mode with rx_pin low, and the line must still sit at mark.

// File: rtl/uart_lb_pkg.sv
// Shared types for the loop router: mode codes and the line idle level.
package uart_lb_pkg;
    typedef enum logic [1:0] {
        LB_NORMAL = 2'b00,
        LB_ECHO   = 2'b01,
        LB_LOCAL  = 2'b10,
        LB_REMOTE = 2'b11
    } lb_mode_e;

    localparam logic LINE_MARK = 1'b1;
endpackage

// File: rtl/lb_tx_drive.sv
// Drives the outgoing line through one register.
// Assumes: rx_pin is already synchronous to clk; reset is synchronous, active low.
module lb_tx_drive
    import uart_lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lb_mode_e mode,
    input  logic     tx_en,
    input  logic     rx_pin,
    input  logic     tx_shift_out,
    output logic     tx_pin
);
    logic line_d;
    logic line_q;

    // Pick the source of the next line level from the mode.
    always_comb begin
        unique case (mode)
            LB_ECHO, LB_REMOTE: line_d = rx_pin;
            LB_LOCAL:           line_d = LINE_MARK;
            default:            line_d = tx_en ? tx_shift_out : LINE_MARK;
        endcase
    end

    // Register the line so it is glitch-free; reset parks it at mark.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= LINE_MARK;
        else        line_q <= line_d;
    end

    assign tx_pin = line_q;

    assert_reset_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> tx_pin == LINE_MARK);
    assert_normal_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_NORMAL && tx_en) |=> tx_pin == $past(tx_shift_out));
    assert_disabled_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_NORMAL && !tx_en) |=> tx_pin == LINE_MARK);
    assert_echo_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_ECHO) |=> tx_pin == $past(rx_pin));
    assert_local_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_LOCAL) |=> tx_pin == LINE_MARK);
    assert_remote_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_REMOTE) |=> tx_pin == $past(rx_pin));
endmodule

// File: rtl/lb_rx_route.sv
// Selects the bit that the receive shifter samples.
// Assumes: the receive shifter does its own oversampling; this is a plain mux.
module lb_rx_route
    import uart_lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lb_mode_e mode,
    input  logic     rx_pin,
    input  logic     tx_shift_out,
    output logic     rx_shift_in
);
    // In local loopback the transmitter feeds the receiver; otherwise the pin does.
    always_comb begin
        rx_shift_in = (mode == LB_LOCAL) ? tx_shift_out : rx_pin;
    end

    assert_local_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_LOCAL) |-> rx_shift_in == tx_shift_out);
    assert_pin_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != LB_LOCAL) |-> rx_shift_in == rx_pin);
endmodule

// File: rtl/lb_cpu_gate.sv
// Grants or blocks the CPU links to the transmitter and the receiver.
// Assumes: requests are single-cycle strobes; grants are combinational.
module lb_cpu_gate
    import uart_lb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lb_mode_e mode,
    input  logic     wr_req,
    input  logic     rd_req,
    output logic     wr_gnt,
    output logic     rd_gnt
);
    logic wr_open;
    logic rd_open;

    // Decide which links the mode leaves open.
    always_comb begin
        wr_open = (mode == LB_NORMAL) || (mode == LB_LOCAL);
        rd_open = (mode != LB_REMOTE);
        wr_gnt  = wr_req && wr_open;
        rd_gnt  = rd_req && rd_open;
    end

    assert_echo_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_ECHO) |-> !wr_gnt && (rd_gnt == rd_req));
    assert_remote_no_links_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_REMOTE) |-> !wr_gnt && !rd_gnt);
    assert_local_links_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LB_LOCAL) |-> (wr_gnt == wr_req) && (rd_gnt == rd_req));
endmodule

// File: rtl/uart_loopback_router.sv
// Loop router for NUM_CH serial channels, one independent slice per channel.
// Assumes: all pins and strobes are synchronous to clk.
module uart_loopback_router
    import uart_lb_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_CH-1:0]   mode,
    input  logic [NUM_CH-1:0]     tx_en,
    input  logic [NUM_CH-1:0]     rx_pin,
    output logic [NUM_CH-1:0]     tx_pin,
    input  logic [NUM_CH-1:0]     tx_shift_out,
    output logic [NUM_CH-1:0]     rx_shift_in,
    input  logic [NUM_CH-1:0]     tx_wr_req,
    output logic [NUM_CH-1:0]     tx_wr_gnt,
    input  logic [NUM_CH-1:0]     rx_rd_req,
    output logic [NUM_CH-1:0]     rx_rd_gnt
);
    localparam int MODE_W = 2;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        lb_mode_e ch_mode;
        // Decode this channel's mode field.
        assign ch_mode = lb_mode_e'(mode[MODE_W*ch +: MODE_W]);

        lb_tx_drive u_tx (
            .clk          (clk),
            .rst_n        (rst_n),
            .mode         (ch_mode),
            .tx_en        (tx_en[ch]),
            .rx_pin       (rx_pin[ch]),
            .tx_shift_out (tx_shift_out[ch]),
            .tx_pin       (tx_pin[ch])
        );

        lb_rx_route u_rx (
            .clk          (clk),
            .rst_n        (rst_n),
            .mode         (ch_mode),
            .rx_pin       (rx_pin[ch]),
            .tx_shift_out (tx_shift_out[ch]),
            .rx_shift_in  (rx_shift_in[ch])
        );

        lb_cpu_gate u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (ch_mode),
            .wr_req (tx_wr_req[ch]),
            .rd_req (rx_rd_req[ch]),
            .wr_gnt (tx_wr_gnt[ch]),
            .rd_gnt (rx_rd_gnt[ch])
        );
    end
endmodule

// File: tb/uart_loopback_router_tb_top.sv
module uart_loopback_router_tb_top;
    localparam int NC = 2;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*NC-1:0] mode = '0;
    logic [NC-1:0] tx_en = '0, rx_pin = '1, tx_shift_out = '1;
    logic [NC-1:0] tx_wr_req = '0, rx_rd_req = '0;
    logic [NC-1:0] tx_pin, rx_shift_in, tx_wr_gnt, rx_rd_gnt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_loopback_router #(.NUM_CH(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tx_en(tx_en),
        .rx_pin(rx_pin), .tx_pin(tx_pin), .tx_shift_out(tx_shift_out),
        .rx_shift_in(rx_shift_in), .tx_wr_req(tx_wr_req), .tx_wr_gnt(tx_wr_gnt),
        .rx_rd_req(rx_rd_req), .rx_rd_gnt(rx_rd_gnt)
    );

    // {mode, en, rx, txo, wr, rd, exp_tx, exp_rxin, exp_wg, exp_rg}
    localparam logic [10:0] VEC [NV] = '{
        11'b00_1_0_0_1_1_0_0_1_1,  // R1 normal
        11'b00_1_1_1_0_1_1_1_0_1,  // R1 normal
        11'b00_1_1_0_1_0_0_1_1_0,  // R1 normal
        11'b00_0_0_0_1_1_1_0_1_1,  // R2 disabled
        11'b01_1_0_1_1_1_0_0_0_1,  // R3 R4 echo
        11'b01_0_1_0_1_0_1_1_0_0,  // R3 R4 echo, disabled
        11'b01_0_0_1_0_1_0_0_0_1,  // R3 R4 echo
        11'b10_1_0_0_1_1_1_0_1_1,  // R5 R6 local
        11'b10_1_1_0_1_1_1_0_1_1,  // R5 local, rx ignored
        11'b10_1_0_1_0_0_1_1_0_0,  // R5 R6 local
        11'b11_1_0_1_1_1_0_0_0_0,  // R7 remote
        11'b11_0_1_0_1_1_1_1_0_0,  // R7 remote
        11'b11_1_0_0_0_0_0_0_0_0,  // R7 remote
        11'b00_1_0_1_1_1_1_0_1_1   // R9 back to normal
    };

    task automatic chk(input string req, input string what,
                       input logic [NC-1:0] act, input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [10:0] v);
        mode         = {NC{v[10:9]}};
        tx_en        = {NC{v[8]}};
        rx_pin       = {NC{v[7]}};
        tx_shift_out = {NC{v[6]}};
        tx_wr_req    = {NC{v[5]}};
        rx_rd_req    = {NC{v[4]}};
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R8: reset in echo mode with rx low still parks the line at mark.
        mode = {NC{2'b01}};
        rx_pin = '0;
        tx_shift_out = '0;
        tx_en = '1;
        repeat (3) @(posedge clk);
        #1 chk("R8", "tx_pin in reset", tx_pin, '1);
        @(negedge clk) rst_n = 1'b1;

        // Vector table: drive at negedge, combinational checks before the edge,
        // registered line check just after the edge.
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k]);
            #2;
            chk($sformatf("R1-set vec%0d rxin", k), "rx_shift_in", rx_shift_in, {NC{VEC[k][2]}});
            chk($sformatf("vec%0d R4 R6 R7 wr", k), "tx_wr_gnt", tx_wr_gnt, {NC{VEC[k][1]}});
            chk($sformatf("vec%0d R4 R6 R7 rd", k), "rx_rd_gnt", rx_rd_gnt, {NC{VEC[k][0]}});
            @(posedge clk);
            #1 chk($sformatf("vec%0d R1 R2 R3 R5 R7 line", k), "tx_pin", tx_pin, {NC{VEC[k][3]}});
        end

        // R9: remote with rx low, then switch to local; old level holds until the edge.
        @(negedge clk);
        drive(11'b11_1_0_0_0_0_0_0_0_0);
        @(posedge clk);
        #1 chk("R9", "tx_pin remote low", tx_pin, '0);
        @(negedge clk);
        mode = {NC{2'b10}};
        #2 chk("R9", "tx_pin before edge", tx_pin, '0);
        @(posedge clk);
        #1 chk("R9", "tx_pin after edge", tx_pin, '1);

        // R10: channel 0 echo, channel 1 normal, different pins.
        @(negedge clk);
        mode = {2'b00, 2'b01};
        tx_en = 2'b11;
        rx_pin = 2'b10;
        tx_shift_out = 2'b01;
        tx_wr_req = 2'b11;
        rx_rd_req = 2'b11;
        #2;
        chk("R10", "tx_wr_gnt", tx_wr_gnt, 2'b10);
        chk("R10", "rx_shift_in", rx_shift_in, 2'b10);
        @(posedge clk);
        #1 chk("R10", "tx_pin", tx_pin, 2'b00);

        // R8: reset in normal mode with shifter low drives mark.
        @(negedge clk);
        mode = '0;
        tx_shift_out = '0;
        rst_n = 1'b0;
        @(posedge clk);
        #1 chk("R8", "tx_pin after reset edge", tx_pin, '1);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 chk("R1", "tx_pin after release", tx_pin, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule